// File: doc/BRIEF.md
# Block Floating-Point Scaling Monitor

This block sets the array-scaling exponent for a fixed-point, multi-pass FFT engine. It watches the complex two's-complement words as they are written into the working array. The first scan covers the incoming sample record. Each later scan covers the arithmetic-unit results of every pass except the final one. For every word it counts the redundant sign bits. The smallest count across one array is the headroom that array holds unused.

When the next pass begins, the block turns that headroom into a left-shift command for the arithmetic unit. It always keeps one guard bit free for the growth of the coming butterflies. It adds each shift it issues to a running exponent. The surrounding logic attaches that exponent to the finished spectrum as its scale factor. The shifter itself lies outside this block.

A transform begins with a start pulse. The record load follows, and each processing pass opens with a pass-start pulse. The pass-start of the final pass carries the last-pass flag. Once the last word of the final pass arrives, the block pulses done and holds its outputs until the next start.

Top module: `bfp_scale_monitor`

## Requirements
- R1: After reset, `shift_amt` and `scale_exp` are 0 and `xform_done` is 0.
- R2: For one 12-bit component, the count is the number of bits below the sign bit that equal the sign bit, taken from the MSB downward. For example, 0x00F and 0xFF0 both count 7, 0x000 and 0xFFF count 11, 0x7FF and 0x800 count 0, 0x3FF counts 1, and 0xE00 counts 2.
- R3: The count of a complex word is the smaller of its real-part count and its imaginary-part count.
- R4: The count of an array is the minimum over the first ARRAY_LEN accepted words of a scan. A start pulse or a pass-start pulse restarts the minimum, so an earlier array does not affect it.
- R5: One cycle after a pass-start pulse, `shift_amt` equals the count of the previous array minus HEADROOM, or 0 when that count is below HEADROOM. The value then stays unchanged until the next pass-start or start.
- R6: A word is ignored when `word_valid` is low, and also when it arrives after the ARRAY_LEN-th word of a scan. An ignored word never changes a later shift.
- R7: Each pass-start adds the newly issued shift to `scale_exp`, so `scale_exp` is the sum of all shifts issued since the start pulse.
- R8: The cycle after the ARRAY_LEN-th word of the last pass, `xform_done` is high for exactly one cycle. After that, pass-start pulses have no effect, and `scale_exp` and `shift_amt` hold until the next start.
- R9: One cycle after a start pulse, `scale_exp` and `shift_amt` are 0 and a new input-record scan has begun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xform_start | input | 1 | Pulse: a new transform begins and the input-record scan opens |
| pass_start | input | 1 | Pulse: a processing pass begins |
| last_pass | input | 1 | Sampled with pass_start: the pass is the final one and is not scanned |
| word_valid | input | 1 | A word is present on word_re and word_im |
| word_re | input | WORD_W | Real component, two's complement |
| word_im | input | WORD_W | Imaginary component, two's complement |
| shift_amt | output | $clog2(WORD_W) | Left-shift command for the current pass |
| scale_exp | output | EXP_W | Sum of the shifts issued in this transform |
| xform_done | output | 1 | One-cycle pulse once the final pass is complete |

## Verification
The bench builds the block with WORD_W = 12, HEADROOM = 1, EXP_W = 8 and ARRAY_LEN = 4. The short array brings pass boundaries, the word-count limit and whole multi-pass transforms within a few cycles each. The 12-bit width allows every extreme count to be placed in either component: all-zero words, all-one words, and the two words that have no spare bits. A table of ten four-word records covers the count patterns. Directed sequences then cover per-pass restart, the summed exponent, ignored words and the frozen state after done.

// File: rtl/bfp_scale_monitor.sv
module bfp_scale_monitor #(
  parameter int WORD_W    = 12,
  parameter int ARRAY_LEN = 256,
  parameter int HEADROOM  = 1,
  parameter int EXP_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       xform_start,
  input  logic                       pass_start,
  input  logic                       last_pass,
  input  logic                       word_valid,
  input  logic [WORD_W-1:0]          word_re,
  input  logic [WORD_W-1:0]          word_im,
  output logic [$clog2(WORD_W)-1:0]  shift_amt,
  output logic [EXP_W-1:0]           scale_exp,
  output logic                       xform_done
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam int LEN_W = $clog2(ARRAY_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] GUARD   = CNT_W'(HEADROOM);
  localparam logic [LEN_W-1:0] LAST_IX = LEN_W'(ARRAY_LEN - 1);

  function automatic logic [CNT_W-1:0] sign_run(input logic [WORD_W-1:0] w);
    logic stop;
    sign_run = '0;
    stop = 1'b0;
    for (int i = WORD_W - 2; i >= 0; i--) begin
      if (!stop) begin
        if (w[i] == w[WORD_W-1]) sign_run = sign_run + 1'b1;
        else stop = 1'b1;
      end
    end
  endfunction

  logic             busy, scanning, final_r, full_r;
  logic [LEN_W-1:0] idx;
  logic [CNT_W-1:0] run_min, pend;

  logic [CNT_W-1:0] cnt_re, cnt_im, word_cnt, base_min, new_min, reserve;
  logic             ps_eff, open_scan, full_eff, accepted, scan_eff, final_eff, last_word;
  logic [LEN_W-1:0] idx_base;

  assign cnt_re    = sign_run(word_re);
  assign cnt_im    = sign_run(word_im);
  assign word_cnt  = (cnt_re < cnt_im) ? cnt_re : cnt_im;

  assign ps_eff    = pass_start && busy && !xform_start;
  assign open_scan = xform_start || ps_eff;
  assign full_eff  = open_scan ? 1'b0 : full_r;
  assign idx_base  = open_scan ? '0 : idx;
  assign accepted  = word_valid && (busy || xform_start) && !full_eff;
  assign scan_eff  = xform_start ? 1'b1 : (ps_eff ? !last_pass : scanning);
  assign final_eff = xform_start ? 1'b0 : (ps_eff ? last_pass : final_r);
  assign last_word = accepted && (idx_base == LAST_IX);

  assign base_min  = open_scan ? CNT_MAX : run_min;
  assign new_min   = (word_cnt < base_min) ? word_cnt : base_min;
  assign reserve   = (new_min >= GUARD) ? new_min - GUARD : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; scanning <= 1'b0; final_r <= 1'b0; full_r <= 1'b0;
      idx <= '0; run_min <= CNT_MAX; pend <= '0;
      shift_amt <= '0; scale_exp <= '0; xform_done <= 1'b0;
    end else begin
      xform_done <= 1'b0;
      if (xform_start) begin
        busy <= 1'b1; shift_amt <= '0; scale_exp <= '0; pend <= '0;
      end else if (ps_eff) begin
        shift_amt <= pend;
        scale_exp <= scale_exp + EXP_W'(pend);
      end
      scanning <= scan_eff;
      final_r  <= final_eff;
      full_r   <= last_word ? 1'b1 : full_eff;
      if (accepted) idx <= idx_base + 1'b1;
      else if (open_scan) idx <= '0;
      if (accepted && scan_eff) run_min <= new_min;
      else if (open_scan) run_min <= CNT_MAX;
      if (last_word && scan_eff) pend <= reserve;
      if (last_word && final_eff) begin
        xform_done <= 1'b1;
        busy <= 1'b0;
      end
    end
  end

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xform_done |=> !xform_done);
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !xform_start) |=> ($stable(scale_exp) && $stable(shift_amt)));
  a_r7_scale_moves_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!xform_start && !pass_start) |=> $stable(scale_exp));
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    xform_start |=> (scale_exp == '0 && shift_amt == '0));
  a_r5_shift_guard: assert property (@(posedge clk) disable iff (!rst_n)
    shift_amt <= CNT_W'(WORD_W - 1 - HEADROOM));
  a_r4_min_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_min <= CNT_MAX);
endmodule

// File: tb/bfp_scale_monitor_tb.sv
`timescale 1ns/1ps
module bfp_scale_monitor_tb;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic xform_start = 0, pass_start = 0, last_pass = 0, word_valid = 0;
  logic [11:0] word_re = 0, word_im = 0;
  logic [3:0] shift_amt;
  logic [7:0] scale_exp;
  logic xform_done;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  bfp_scale_monitor #(.WORD_W(12), .ARRAY_LEN(N), .HEADROOM(1), .EXP_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .xform_start(xform_start), .pass_start(pass_start),
    .last_pass(last_pass), .word_valid(word_valid), .word_re(word_re), .word_im(word_im),
    .shift_amt(shift_amt), .scale_exp(scale_exp), .xform_done(xform_done));

  // expected shift in top nibble, then four words of {re, im}
  localparam logic [99:0] VEC [10] = '{
    100'hA_000000_000000_000000_000000,
    100'h6_00F000_000000_000000_000000,
    100'h6_000000_000000_000FF0_000000,
    100'h1_000000_100000_000000_000FF0,
    100'h0_000000_000000_000000_0007FF,
    100'h0_800000_000000_000000_000000,
    100'h0_000000_000000_3FF000_000000,
    100'hA_FFFFFF_FFFFFF_FFFFFF_FFFFFF,
    100'h1_FFFFFF_E00FFF_FFFFFF_FFFFFF,
    100'h2_000000_000000_000000_080000
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic st, input logic ps, input logic lp, input logic v,
                     input logic [11:0] re, input logic [11:0] im);
    xform_start = st; pass_start = ps; last_pass = lp; word_valid = v;
    word_re = re; word_im = im;
    @(negedge clk);
    xform_start = 0; pass_start = 0; last_pass = 0; word_valid = 0;
    word_re = 0; word_im = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 shift", int'(shift_amt), 0);
    chk("R1 scale", int'(scale_exp), 0);
    chk("R1 done", int'(xform_done), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R5: per-record counts
    for (int e = 0; e < 10; e++) begin
      put(1, 0, 0, 0, 0, 0);
      for (int k = 0; k < N; k++)
        put(0, 0, 0, 1, VEC[e][95-24*k -: 12], VEC[e][83-24*k -: 12]);
      put(0, 1, 0, 0, 0, 0);
      chk($sformatf("R2/R3/R5 vec%0d shift", e), int'(shift_amt), int'(VEC[e][99:96]));
      chk($sformatf("R7 vec%0d scale", e), int'(scale_exp), int'(VEC[e][99:96]));
    end

    // R6: invalid word and excess word are ignored
    put(1, 0, 0, 0, 0, 0);
    put(0, 0, 0, 0, 12'h800, 12'h800);
    for (int k = 0; k < N; k++) put(0, 0, 0, 1, 0, 0);
    put(0, 0, 0, 1, 12'h800, 12'h7FF);
    put(0, 1, 0, 0, 0, 0);
    chk("R6 shift", int'(shift_amt), 10);

    // R4 R7 R8 R9: multi-pass transform
    put(1, 0, 0, 0, 0, 0);
    chk("R9 scale", int'(scale_exp), 0);
    chk("R9 shift", int'(shift_amt), 0);
    for (int k = 0; k < N; k++) put(0, 0, 0, 1, 12'h100, 0);
    put(0, 1, 0, 0, 0, 0);
    chk("R5 pass1 shift", int'(shift_amt), 1);
    chk("R7 pass1 scale", int'(scale_exp), 1);
    for (int k = 0; k < N; k++) put(0, 0, 0, 1, 12'h03F, 12'hFC0);
    put(0, 1, 1, 0, 0, 0);
    chk("R4 restart shift", int'(shift_amt), 4);
    chk("R7 sum scale", int'(scale_exp), 5);
    for (int k = 0; k < N - 1; k++) put(0, 0, 0, 1, 12'h800, 12'h800);
    chk("R8 done early", int'(xform_done), 0);
    put(0, 0, 0, 1, 12'h800, 12'h800);
    chk("R8 done", int'(xform_done), 1);
    put(0, 0, 0, 0, 0, 0);
    chk("R8 done pulse", int'(xform_done), 0);
    put(0, 1, 0, 0, 0, 0);
    chk("R8 frozen scale", int'(scale_exp), 5);
    chk("R8 frozen shift", int'(shift_amt), 4);
    put(1, 0, 0, 0, 0, 0);
    chk("R9 restart scale", int'(scale_exp), 0);
    chk("R9 restart shift", int'(shift_amt), 0);
    chk("R9 restart done", int'(xform_done), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule